// File: doc/BRIEF.md
# Integer-Float Multiply Pipeline

This block takes two signed 16-bit integer samples, turns each into a single-precision binary floating-point value, multiplies the two values and converts the product back to a signed 16-bit integer. The three stages are pipelined with fixed latencies of 3, 3 and 2 cycles. A result therefore leaves the block 8 accepted clock cycles after its operands enter. With no back-pressure, a new operand pair can enter on every clock.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. Back-pressure works as follows. `in_ready` equals `out_ready`. While `out_ready` is low, every pipeline register holds its value. `out_valid` and `out_data` then stay unchanged, and a pair offered on the input is not accepted. While `out_ready` is high, the pipeline moves forward one stage per clock.

Three debug outputs show the internal values. `dbg_fa` and `dbg_fb` show the converted operands. `dbg_prod` shows the floating-point product.

Top module: `int_fmul_pipe`

## Requirements
- R1: With `out_ready` held high, an operand pair accepted on clock edge k gives `out_valid` = 1 right after edge k+7 and not before. Pairs accepted on consecutive edges give results on consecutive edges, in the same order.
- R2: Each non-zero operand is encoded on `dbg_fa`/`dbg_fb` 3 cycles after acceptance. The encoding is exact: bit 31 is the sign, bits 30:23 are the exponent with bias 127, and bits 22:0 are the fraction without the hidden bit.
- R3: An operand of 0 is encoded as 32'h00000000 (positive zero).
- R4: `dbg_prod` shows the product of the two encoded operands 6 cycles after acceptance. The product is rounded to nearest, with ties going to the even fraction.
- R5: If either operand is zero, `dbg_prod` is 32'h00000000 and `out_data` is 0. Products too small to be normal are flushed to zero, so no denormal value ever appears on `dbg_prod`.
- R6: When the exact integer product lies in [-32768, 32767], `out_data` equals that product. Its sign is the exclusive-or of the operand signs.
- R7: A product above 32767 gives 32767. A product below -32768 gives -32768. A product exponent that overflows gives infinity, which the output converter saturates.
- R8: `in_ready` follows `out_ready`. While `out_ready` is low, `out_valid` and `out_data` are held. A pair offered while `in_ready` is low is not accepted and never produces a result.
- R9: A synchronous active-high `rst` clears every pipeline valid bit. A pair that is in flight when reset arrives never produces a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pair is accepted on this edge if in_valid is also high |
| in_a | input | 16 | First operand, two's complement |
| in_b | input | 16 | Second operand, two's complement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result; low freezes the pipeline |
| out_data | output | 16 | Saturated product, two's complement |
| dbg_fa | output | 32 | Converted first operand |
| dbg_fb | output | 32 | Converted second operand |
| dbg_prod | output | 32 | Floating-point product |

## Verification
A fault in an input converter, such as a wrong leading-one position or a wrong exponent, shows up on `dbg_fa` or `dbg_fb` 3 cycles after the operands are accepted. It then spreads to `dbg_prod` at 6 cycles and to `out_data` at 8 cycles. A rounding or normalisation fault in the multiplier appears only on `dbg_prod`, and only for products wider than 24 bits. Those products saturate at the output, so the debug port is the only place such a fault can be seen. A stage that slips or drops its valid bit changes the cycle in which `out_valid` rises, or whether it rises at all. This makes latency, stall and reset faults visible within 8 accepted cycles.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int FLT_W   = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int BIAS    = 127;
  localparam int EXP_TOP = (1 << EXP_W) - 1;
  typedef logic [FLT_W-1:0] flt_t;
endpackage

// File: rtl/fmul_i2f.sv
module fmul_i2f
  import fmul_pkg::*;
#(
  parameter int LANES = 2,
  parameter int IW    = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      adv,
  input  logic                      in_valid,
  input  logic [LANES-1:0][IW-1:0]  in_int,
  output logic                      out_valid,
  output flt_t [LANES-1:0]          out_flt
);
  localparam int PW = $clog2(IW);

  logic v1, v2, v3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end
  assign out_valid = v3;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic          s1_sign;
    logic [IW-1:0] s1_mag;
    logic [PW-1:0] msb_pos;
    logic [IW-1:0] shifted;
    logic          s2_sign;
    logic          s2_zero;
    logic [EXP_W-1:0] s2_exp;
    logic [IW-2:0] s2_frac;
    flt_t          s3_flt;

    always_comb begin
      msb_pos = '0;
      for (int i = 0; i < IW; i++) begin
        if (s1_mag[i]) msb_pos = PW'(i);
      end
      shifted = s1_mag << (PW'(IW - 1) - msb_pos);
    end

    always_ff @(posedge clk) begin
      if (adv) begin
        s1_sign <= in_int[g][IW-1];
        s1_mag  <= in_int[g][IW-1] ? (~in_int[g] + 1'b1) : in_int[g];
        s2_sign <= s1_sign;
        s2_zero <= ~shifted[IW-1];
        s2_exp  <= EXP_W'(BIAS) + EXP_W'(msb_pos);
        s2_frac <= shifted[IW-2:0];
        s3_flt  <= s2_zero ? '0 :
                   {s2_sign, s2_exp, FRAC_W'(s2_frac) << (FRAC_W - IW + 1)};
      end
    end

    assign out_flt[g] = s3_flt;

    AST_I2F_EXP_RANGE: assert property (@(posedge clk) disable iff (rst)
      (v3 && s3_flt[FLT_W-2:0] != '0) |->
        (s3_flt[FLT_W-2:FRAC_W] >= EXP_W'(BIAS) &&
         s3_flt[FLT_W-2:FRAC_W] <= EXP_W'(BIAS + IW - 1))); // R2
    AST_I2F_POS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (v3 && s3_flt[FLT_W-2:FRAC_W] == '0) |-> (s3_flt == '0)); // R3
  end
endmodule

// File: rtl/fmul_core.sv
module fmul_core
  import fmul_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic in_valid,
  input  flt_t in_a,
  input  flt_t in_b,
  output logic out_valid,
  output flt_t out_flt
);
  localparam int EW = EXP_W + 2;
  localparam int PRW = 2 * MANT_W;

  logic v1, v2, v3;
  logic s1_sign, s1_zero, s1_inf;
  logic signed [EW-1:0] s1_exp;
  logic [MANT_W-1:0] s1_ma, s1_mb;
  logic s2_sign, s2_zero, s2_inf;
  logic signed [EW-1:0] s2_exp;
  logic [PRW-1:0] s2_prod;
  flt_t s3_flt;

  logic [EXP_W-1:0] ea, eb;
  logic top;
  logic [MANT_W-1:0] mant;
  logic grd, stk, rnd;
  logic [MANT_W:0] mant_r;
  logic signed [EW:0] e_n, e_f;
  logic [FRAC_W-1:0] frac_f;
  flt_t res;

  assign ea = in_a[FLT_W-2:FRAC_W];
  assign eb = in_b[FLT_W-2:FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_comb begin
    top = s2_prod[PRW-1];
    if (top) begin
      mant = s2_prod[PRW-1:MANT_W];
      grd  = s2_prod[MANT_W-1];
      stk  = |s2_prod[MANT_W-2:0];
    end else begin
      mant = s2_prod[PRW-2:MANT_W-1];
      grd  = s2_prod[MANT_W-2];
      stk  = |s2_prod[MANT_W-3:0];
    end
    rnd    = grd & (stk | mant[0]);
    mant_r = {1'b0, mant} + {{MANT_W{1'b0}}, rnd};
    frac_f = mant_r[MANT_W] ? mant_r[MANT_W-1:1] : mant_r[MANT_W-2:0];
    e_n    = {s2_exp[EW-1], s2_exp} + (top ? (EW+1)'(1) : (EW+1)'(0));
    e_f    = e_n + {{EW{1'b0}}, mant_r[MANT_W]};
    if (s2_zero)
      res = '0;
    else if (s2_inf || e_f >= (EW+1)'(EXP_TOP))
      res = {s2_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (e_f <= (EW+1)'(0))
      res = '0;
    else
      res = {s2_sign, e_f[EXP_W-1:0], frac_f};
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_sign <= in_a[FLT_W-1] ^ in_b[FLT_W-1];
      s1_zero <= (ea == '0) | (eb == '0);
      s1_inf  <= (ea == EXP_W'(EXP_TOP)) | (eb == EXP_W'(EXP_TOP));
      s1_exp  <= $signed({2'b00, ea}) + $signed({2'b00, eb}) - EW'(BIAS);
      s1_ma   <= {1'b1, in_a[FRAC_W-1:0]};
      s1_mb   <= {1'b1, in_b[FRAC_W-1:0]};
      s2_sign <= s1_sign;
      s2_zero <= s1_zero;
      s2_inf  <= s1_inf;
      s2_exp  <= s1_exp;
      s2_prod <= s1_ma * s1_mb;
      s3_flt  <= res;
    end
  end

  assign out_valid = v3;
  assign out_flt   = s3_flt;

  AST_NO_DENORM: assert property (@(posedge clk) disable iff (rst)
    (v3 && s3_flt[FLT_W-2:FRAC_W] == '0) |-> (s3_flt[FRAC_W-1:0] == '0)); // R5
endmodule

// File: rtl/fmul_f2i.sv
module fmul_f2i
  import fmul_pkg::*;
#(
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          in_valid,
  input  flt_t          in_flt,
  output logic          out_valid,
  output logic [OW-1:0] out_int
);
  localparam int FW = 2 * MANT_W;
  localparam logic [OW:0]   POS_LIM = {2'b00, {(OW-1){1'b1}}};
  localparam logic [OW:0]   NEG_LIM = {2'b01, {(OW-1){1'b0}}};
  localparam logic [OW-1:0] POS_SAT = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] NEG_SAT = {1'b1, {(OW-1){1'b0}}};

  logic v1, v2;
  logic [EXP_W-1:0] e;
  int unsigned_e, ue, sh;
  logic [FW-1:0] fixd;
  logic sat_c, zero_c;

  logic s1_sign, s1_sat, s1_zero, s1_grd, s1_stk;
  logic [OW:0] s1_int;
  logic [OW:0] r;
  logic [OW-1:0] res;

  assign e = in_flt[FLT_W-2:FRAC_W];

  always_comb begin
    unsigned_e = int'(e);
    ue   = unsigned_e - BIAS;
    sh   = FRAC_W - ue;
    fixd = {1'b1, in_flt[FRAC_W-1:0], {MANT_W{1'b0}}} >> sh;
    sat_c  = (e == EXP_W'(EXP_TOP)) || (ue >= OW - 1);
    zero_c = (e == '0) || (ue < -1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  always_comb begin
    r = s1_int + {{OW{1'b0}}, s1_grd & (s1_stk | s1_int[0])};
    if (s1_zero)
      res = '0;
    else if (!s1_sign)
      res = (s1_sat || r > POS_LIM) ? POS_SAT : r[OW-1:0];
    else
      res = (s1_sat || r > NEG_LIM) ? NEG_SAT : OW'(~r + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_sign <= in_flt[FLT_W-1];
      s1_zero <= zero_c;
      s1_sat  <= sat_c | (|fixd[FW-1:MANT_W+OW+1]);
      s1_int  <= fixd[MANT_W+OW:MANT_W];
      s1_grd  <= fixd[MANT_W-1];
      s1_stk  <= |fixd[MANT_W-2:0];
      out_int <= res;
    end
  end

  assign out_valid = v2;

  AST_SAT_ON_INF: assert property (@(posedge clk) disable iff (rst)
    (adv && in_valid && e == EXP_W'(EXP_TOP)) |=> s1_sat); // R7
endmodule

// File: rtl/int_fmul_pipe.sv
module int_fmul_pipe
  import fmul_pkg::*;
#(
  parameter int IW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_a,
  input  logic [IW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data,
  output logic [31:0]   dbg_fa,
  output logic [31:0]   dbg_fb,
  output logic [31:0]   dbg_prod
);
  logic adv;
  logic cv_valid, mul_valid;
  flt_t [1:0] cv_flt;
  flt_t mul_flt;

  assign adv      = out_ready;
  assign in_ready = out_ready;

  fmul_i2f #(.LANES(2), .IW(IW)) u_i2f (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_valid (in_valid),
    .in_int   ({in_b, in_a}),
    .out_valid(cv_valid),
    .out_flt  (cv_flt)
  );

  fmul_core u_mul (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_valid (cv_valid),
    .in_a     (cv_flt[0]),
    .in_b     (cv_flt[1]),
    .out_valid(mul_valid),
    .out_flt  (mul_flt)
  );

  fmul_f2i #(.OW(OW)) u_f2i (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_valid (mul_valid),
    .in_flt   (mul_flt),
    .out_valid(out_valid),
    .out_int  (out_data)
  );

  assign dbg_fa   = cv_flt[0];
  assign dbg_fb   = cv_flt[1];
  assign dbg_prod = mul_flt;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_ready |=> ($stable(out_valid) && $stable(out_data))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R9
endmodule

// File: tb/int_fmul_pipe_tb.sv
`timescale 1ns/1ps
module int_fmul_pipe_tb;
  localparam int N = 13;
  localparam logic signed [15:0] VA [N] = '{16'sd5, 16'sd0, -16'sd3, -16'sd300, 16'sd181,
    16'sd182, -16'sd32768, -16'sd32768, 16'sd32767, 16'sd4097, -16'sd200, 16'sd1, -16'sd1};
  localparam logic signed [15:0] VB [N] = '{16'sd1234, 16'sd777, 16'sd7, -16'sd100, 16'sd181,
    16'sd182, 16'sd1, -16'sd1, 16'sd32767, 16'sd4097, 16'sd200, 16'sd1, 16'sd0};
  localparam logic signed [15:0] VE [N] = '{16'sd6170, 16'sd0, -16'sd21, 16'sd30000, 16'sd32761,
    16'sd32767, -16'sd32768, 16'sd32767, 16'sd32767, 16'sd32767, -16'sd32768, 16'sd1, 16'sd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [15:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [15:0] out_data;
  logic [31:0] dbg_fa, dbg_fb, dbg_prod;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  int_fmul_pipe u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .dbg_fa(dbg_fa), .dbg_fb(dbg_fb), .dbg_prod(dbg_prod)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_i2f(input logic signed [15:0] v);
    int m, p;
    m = (v < 0) ? -int'(v) : int'(v);
    if (m == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 17; i++) if (m[i]) p = i;
    return {v < 0, 8'(127 + p), 23'(m << (23 - p))};
  endfunction

  function automatic logic [31:0] ref_mul(input logic signed [15:0] a, input logic signed [15:0] b);
    longint pr, m, rem, half, mm;
    int p, sh;
    pr = longint'(a) * longint'(b);
    m = (pr < 0) ? -pr : pr;
    if (m == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 32; i++) if (m[i]) p = i;
    if (p <= 23) mm = m << (23 - p);
    else begin
      sh = p - 23;
      mm = m >> sh;
      rem = m & ((64'sd1 << sh) - 1);
      half = 64'sd1 << (sh - 1);
      if (rem > half || (rem == half && mm[0])) mm++;
      if (mm == (64'sd1 << 24)) begin mm = mm >> 1; p++; end
    end
    return {pr < 0, 8'(127 + p), 23'(mm)};
  endfunction

  task automatic run_vec(input logic signed [15:0] a, input logic signed [15:0] b,
                         input logic signed [15:0] e);
    @(negedge clk); in_valid = 1'b1; in_a = a; in_b = b;
    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(dbg_fa == ref_i2f(a), (a == 0) ? "R3 zero operand a" : "R2 operand a", dbg_fa, ref_i2f(a));
    chk(dbg_fb == ref_i2f(b), (b == 0) ? "R3 zero operand b" : "R2 operand b", dbg_fb, ref_i2f(b));
    repeat (3) @(negedge clk);
    chk(dbg_prod == ref_mul(a, b), (a == 0 || b == 0) ? "R5 zero product" : "R4 product",
        dbg_prod, ref_mul(a, b));
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 no early valid", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R1 valid at 8", 32'(out_valid), 32'd1);
    chk(out_data == e, "R6/R7 result", 32'(out_data), 32'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset state", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R8 in_ready follows out_ready", 32'(in_ready), 32'd1);
    rst = 1'b0;

    for (int i = 0; i < N; i++) run_vec(VA[i], VB[i], VE[i]);

    // R1: back-to-back stream
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; in_a = VA[i + 2]; in_b = VB[i + 2];
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 stream no early valid", 32'(out_valid), 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == VE[i + 2], "R1 stream order", 32'(out_data), 32'(VE[i + 2]));
    end

    // R8: back-pressure
    @(negedge clk); in_valid = 1'b1; in_a = 16'sd7; in_b = -16'sd9;
    @(negedge clk); out_ready = 1'b0; in_a = 16'sd100; in_b = 16'sd100;
    chk(in_ready == 1'b0, "R8 in_ready low", 32'(in_ready), 32'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 frozen empty", 32'(out_valid), 32'd0);
    end
    out_ready = 1'b1; in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(out_valid == 1'b0, "R8 resume latency", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk(out_valid && out_data == 16'hFFC1, "R8 result after stall", 32'(out_data), 32'hFFC1);
    out_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == 16'hFFC1, "R8 output held", 32'(out_data), 32'hFFC1);
    end
    out_ready = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 ignored pair absent", 32'(out_valid), 32'd0);
    end

    // R9: reset flushes in-flight pair
    @(negedge clk); in_valid = 1'b1; in_a = 16'sd3; in_b = 16'sd3;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 flushed", 32'(out_valid), 32'd0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule